// File: doc/BRIEF.md
# Two-Row Character Overlay Generator

This block draws a small text panel on top of a video raster. The panel holds two rows of six character cells. Each cell shows a 5 by 7 dot glyph in one of eight colours. The block counts clocks from the rising edge of an active-low horizontal sync and counts lines from the falling edge of an active-low vertical sync. From these counts it produces red, green and blue overlay bits and a fast-blanking bit. The fast-blanking bit tells the video path when to switch from the picture to the overlay.

Software writes the twelve cell registers and four control registers through a simple write port. The control registers set the dot scale, the coarse panel position, the background style, the special-code handling and a set of test gates. All writes land in shadow copies. The shadow copies are moved to the working copies only at the start of a field, so a frame is never drawn from a half-updated setup.

Within each cell the glyph may be smoothed on a half-dot grid. The panel can have no background, a one-pixel halo around each glyph, or a solid rectangle. The two extreme character codes can act as blank and as cell-off markers.

Top module: `osd_text_overlay`

## Requirements
- R1: After reset every output is low. All registers clear to zero, so the overlay is disabled until software enables it and a field starts.
- R2: Addresses 0 to 11 are cell registers, with index = row*6 + column (row 0 on top, column 0 on the left). In a cell register, bits 4:0 hold the character code, bit 7 is red, bit 6 is green and bit 5 is blue.
- R3: Register writes reach the drawing logic only when a falling vsync_n edge is detected. A write in the same cycle as that detection takes effect one field later.
- R4: Column x counts the clocks since a rising hsync_n edge. The clock edge that detects the rise sets x to 0. The outputs after the (x+2)-th rising clock edge that follows the hsync_n rise show column x. Line y is the number of hsync_n rises since the last vsync_n fall.
- R5: Register 12 bits 3:0 give vpos, and bits 5:4 give the scale s minus 1. Register 13 bits 4:0 give hpos. The panel starts at x0 = 12*hpos and y0 = 18*vpos. Its pixel coordinates are px = floor((x-x0)/s) and py = floor((y-y0)/s), with 0<=px<74 and 0<=py<36. Nothing is drawn outside the panel.
- R6: The glyph of the cell in row r and column c covers px 12c+2 to 12c+11 and py 18r+2 to 18r+15. Each glyph dot is a 2x2 pixel square. Dot row g (0 at the top) of code k has the pattern ((k*(g+1)) xor 2g) mod 32, and its bit 4 is the leftmost dot.
- R7: Smoothing lights a pixel whose own dot is clear when both the dot beside it (on the side of its half-dot) and the dot above or below it (on that side) are set. Neighbours outside the 5x7 glyph count as clear. Register 15 bit 1 turns smoothing off.
- R8: Register 14 bit 2 selects a solid background. Otherwise, register 14 bit 1 selects a halo: every unlit pixel of a cell next to a lit pixel of that cell, in any of the eight directions, takes the background colour. The background colour is register 14 bits 7:5 (red, green, blue).
- R9: Code 0 draws nothing in its glyph unless register 14 bit 3 is set. Code 31 turns its cell off unless register 14 bit 4 is set. In solid mode an off cell shows nothing over px 12c+1 to 12c+12 and py 18r+1 to 18r+16.
- R10: Register 14 bit 0 enables the overlay. Fast blanking is high on every pixel that drives a glyph or background colour, black included. A lit glyph pixel takes the cell colour, which wins over the background.
- R11: Register 15 is the test register. Bit 0 enables test mode. Bit 2 gates fast blanking, and bits 3, 4 and 5 gate red, green and blue. When bit 0 is clear, all of its bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| hsync_n | input | 1 | Active-low horizontal sync |
| vsync_n | input | 1 | Active-low vertical sync |
| r_out | output | 1 | Red overlay bit |
| g_out | output | 1 | Green overlay bit |
| b_out | output | 1 | Blue overlay bit |
| fb_out | output | 1 | Fast-blanking bit |

## Verification
A register write and the start of a field can fall in the same cycle. The write must then miss the field that starts and show only in the next one. The bench provokes this by raising the write strobe on the same clock that drops vsync_n, writing a mode value that differs from the pending one. It judges the result by comparing every pixel of the following field, and of the field after it, against a model that loads its working copy before applying the write. A write in the middle of a field is also checked: the rest of that field must still be drawn from the old setup.

// File: rtl/osd_text_overlay.sv
module osd_text_overlay #(
  parameter int CW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       hsync_n,
  input  logic       vsync_n,
  output logic       r_out,
  output logic       g_out,
  output logic       b_out,
  output logic       fb_out
);
  localparam int BLK_W  = 74;
  localparam int BLK_H  = 36;
  localparam int STEP_X = 12;
  localparam int STEP_Y = 18;
  localparam logic [CW-1:0] CMAX = '1;

  logic hs_d, vs_d;
  logic [CW-1:0] x, y;
  logic [11:0][7:0] cell_s, cell_a;
  logic [5:0] geo_s, geo_a, ts_s, ts_a;
  logic [4:0] hp_s, hp_a;
  logic [7:0] md_s, md_a;

  wire h_rise = hsync_n & ~hs_d;
  wire v_fall = ~vsync_n & vs_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cell_s <= '0; cell_a <= '0;
      geo_s <= '0; geo_a <= '0;
      hp_s <= '0; hp_a <= '0;
      md_s <= '0; md_a <= '0;
      ts_s <= '0; ts_a <= '0;
    end else begin
      if (wr_en)
        case (wr_addr)
          4'd12: geo_s <= wr_data[5:0];
          4'd13: hp_s <= wr_data[4:0];
          4'd14: md_s <= wr_data;
          4'd15: ts_s <= wr_data[5:0];
          default: cell_s[wr_addr] <= wr_data;
        endcase
      if (v_fall) begin
        cell_a <= cell_s;
        geo_a <= geo_s;
        hp_a <= hp_s;
        md_a <= md_s;
        ts_a <= ts_s[0] ? ts_s : 6'd0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_d <= 1'b1; vs_d <= 1'b1;
      x <= '0; y <= '0;
    end else begin
      hs_d <= hsync_n;
      vs_d <= vsync_n;
      x <= h_rise ? '0 : (x == CMAX ? x : x + 1'b1);
      if (v_fall) y <= '0;
      else if (h_rise && y != CMAX) y <= y + 1'b1;
    end

  function automatic logic [CW-1:0] shrink(input logic [CW-1:0] v, input logic [1:0] m);
    case (m)
      2'd0: return v;
      2'd1: return v >> 1;
      2'd2: return v / CW'(3);
      default: return v >> 2;
    endcase
  endfunction

  function automatic logic [4:0] glyph_row(input logic [4:0] code, input int row);
    logic [7:0] p;
    p = 8'(code) * 8'(row + 1);
    return p[4:0] ^ 5'(row * 2);
  endfunction

  function automatic logic dot_at(input logic [4:0] code, input int gx, input int gy);
    logic [4:0] bits;
    if (gx < 0 || gx > 4 || gy < 0 || gy > 6) return 1'b0;
    bits = glyph_row(code, gy);
    return bits[4 - gx];
  endfunction

  function automatic logic pix_on(input logic [4:0] code, input int lx, input int ly, input logic smooth);
    int gx, gy, hx, vy;
    if (lx < 0 || lx > 9 || ly < 0 || ly > 13) return 1'b0;
    gx = lx / 2;
    gy = ly / 2;
    if (dot_at(code, gx, gy)) return 1'b1;
    if (!smooth) return 1'b0;
    hx = (lx % 2 == 1) ? gx + 1 : gx - 1;
    vy = (ly % 2 == 1) ? gy + 1 : gy - 1;
    return dot_at(code, hx, gy) && dot_at(code, gx, vy);
  endfunction

  logic [CW-1:0] x0, y0, px, py;
  logic in_blk;
  assign x0 = CW'(hp_a) * CW'(STEP_X);
  assign y0 = CW'(geo_a[3:0]) * CW'(STEP_Y);
  assign px = shrink(x - x0, geo_a[5:4]);
  assign py = shrink(y - y0, geo_a[5:4]);
  assign in_blk = (x >= x0) && (y >= y0) && (px < CW'(BLK_W)) && (py < CW'(BLK_H));

  wire en       = md_a[0];
  wire fringe   = md_a[1];
  wire square   = md_a[2];
  wire show0    = md_a[3];
  wire show31   = md_a[4];
  wire smooth   = ~ts_a[1];

  logic colok, rowok, cell_in, blank, off, glyph_on, halo;
  int ccol, crow, lx, ly;
  logic [7:0] cdat;

  always_comb begin
    colok = (px >= CW'(1)) && (px <= CW'(72));
    ccol = colok ? (int'(px) - 1) / STEP_X : 0;
    lx = int'(px) - STEP_X * ccol - 2;
    rowok = 1'b1;
    crow = 0;
    ly = int'(py) - 2;
    if (py >= CW'(19) && py <= CW'(34)) begin
      crow = 1;
      ly = int'(py) - 20;
    end else if (!(py >= CW'(1) && py <= CW'(16))) rowok = 1'b0;
    cell_in = colok && rowok;
    cdat = cell_a[4'(crow * 6 + ccol)];
    blank = (cdat[4:0] == 5'd0) && !show0;
    off = (cdat[4:0] == 5'd31) && !show31;
    glyph_on = cell_in && !blank && !off && pix_on(cdat[4:0], lx, ly, smooth);
    halo = 1'b0;
    if (cell_in && !blank && !off && !glyph_on)
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++)
          if (dx != 0 || dy != 0)
            halo = halo | pix_on(cdat[4:0], lx + dx, ly + dy, smooth);
  end

  logic [2:0] rgb_n;
  logic fb_n;
  always_comb begin
    rgb_n = 3'b000;
    fb_n = 1'b0;
    if (en && in_blk) begin
      if (glyph_on) begin
        rgb_n = cdat[7:5]; fb_n = 1'b1;
      end else if (square && !(cell_in && off)) begin
        rgb_n = md_a[7:5]; fb_n = 1'b1;
      end else if (!square && fringe && halo) begin
        rgb_n = md_a[7:5]; fb_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_out <= 1'b0; g_out <= 1'b0; b_out <= 1'b0; fb_out <= 1'b0;
    end else begin
      r_out  <= rgb_n[2] & ~ts_a[3];
      g_out  <= rgb_n[1] & ~ts_a[4];
      b_out  <= rgb_n[0] & ~ts_a[5];
      fb_out <= fb_n & ~ts_a[2];
    end

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_fall |=> $stable({cell_a, geo_a, hp_a, md_a, ts_a}));

  // R10
  fb_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_out | g_out | b_out) |-> (fb_out || $past(ts_a[2])));

  // R5
  outside_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!in_blk || !en) |-> !(r_out | g_out | b_out | fb_out));

  // R9
  off_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cell_in && off) |-> !(r_out | g_out | b_out | fb_out));

  // R11
  test_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_a[0] |-> (ts_a == 6'd0));
endmodule

// File: tb/osd_text_overlay_test.sv
`timescale 1ns/1ps
module osd_text_overlay_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, hsync_n = 1'b1, vsync_n = 1'b1;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic r_out, g_out, b_out, fb_out;

  osd_text_overlay uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .r_out(r_out), .g_out(g_out), .b_out(b_out), .fb_out(fb_out));

  typedef struct { logic [3:0] e; string tag; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0, ycur = 0;
  string cur_tag = "R1";
  logic [7:0] shd [16];
  logic [7:0] act [16];
  bit done = 0;

  task automatic check_out(string tag, logic [3:0] e);
    logic [3:0] got;
    got = {r_out, g_out, b_out, fb_out};
    n_chk++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s got rgbf=%b expected %b", tag, got, e);
    end
  endtask

  function automatic bit m_dot(int code, int gx, int gy);
    int v;
    if (gx < 0 || gx > 4 || gy < 0 || gy > 6) return 0;
    v = ((code * (gy + 1)) ^ (gy * 2)) & 31;
    return ((v >> (4 - gx)) & 1) == 1;
  endfunction

  function automatic bit m_lit(int code, int lx, int ly, bit sm);
    int gx, gy, nx, ny;
    if (lx < 0 || lx > 9 || ly < 0 || ly > 13) return 0;
    gx = lx / 2; gy = ly / 2;
    if (m_dot(code, gx, gy)) return 1;
    if (!sm) return 0;
    nx = gx + ((lx % 2 == 1) ? 1 : -1);
    ny = gy + ((ly % 2 == 1) ? 1 : -1);
    return m_dot(code, nx, gy) && m_dot(code, gx, ny);
  endfunction

  function automatic logic [3:0] exp_pix(int x, int y);
    int s, x0, y0, px, py, lx, ly, code;
    bit lit, halo, offreg, sm;
    logic [2:0] col, rgb;
    logic f;
    if (!act[14][0]) return 4'b0;
    s = int'(act[12][5:4]) + 1;
    x0 = 12 * int'(act[13][4:0]);
    y0 = 18 * int'(act[12][3:0]);
    if (x < x0 || y < y0) return 4'b0;
    px = (x - x0) / s; py = (y - y0) / s;
    if (px > 73 || py > 35) return 4'b0;
    sm = !act[15][1];
    lit = 0; halo = 0; offreg = 0; col = 3'b0;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 6; c++) begin
        lx = px - (12 * c + 2); ly = py - (18 * r + 2);
        if (lx >= -1 && lx <= 10 && ly >= -1 && ly <= 14) begin
          code = int'(act[r * 6 + c][4:0]);
          if (code == 31 && !act[14][4]) offreg = 1;
          else if (!(code == 0 && !act[14][3])) begin
            if (m_lit(code, lx, ly, sm)) begin
              lit = 1; col = act[r * 6 + c][7:5];
            end else
              for (int a = -1; a <= 1; a++)
                for (int b = -1; b <= 1; b++)
                  if (m_lit(code, lx + a, ly + b, sm)) halo = 1;
          end
        end
      end
    rgb = 3'b0; f = 1'b0;
    if (lit) begin rgb = col; f = 1'b1; end
    else if (act[14][2] && !offreg) begin rgb = act[14][7:5]; f = 1'b1; end
    else if (!act[14][2] && act[14][1] && halo) begin rgb = act[14][7:5]; f = 1'b1; end
    return {rgb[2] & !act[15][3], rgb[1] & !act[15][4], rgb[0] & !act[15][5], f & !act[15][2]};
  endfunction

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shd[a] = d;
  endtask

  task automatic vfield(bit dw, int a, logic [7:0] d);
    @(negedge clk);
    vsync_n = 1'b0;
    if (dw) begin wr_en = 1'b1; wr_addr = 4'(a); wr_data = d; end
    for (int i = 0; i < 16; i++) act[i] = shd[i];
    if (!shd[15][0]) act[15] = 8'h0;
    if (dw) shd[a] = d;
    ycur = 0;
    @(negedge clk);
    vsync_n = 1'b1; wr_en = 1'b0;
  endtask

  task automatic one_line(bit chk, int len);
    item_t it;
    @(negedge clk) hsync_n = 1'b0;
    @(negedge clk) hsync_n = 1'b1;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (chk && i >= 2) begin
        it.e = exp_pix(i - 2, ycur);
        it.tag = cur_tag;
        q.push_back(it);
      end
    end
  endtask

  task automatic lines(int n, int first_chk, int len);
    for (int k = 0; k < n; k++) begin
      ycur++;
      one_line(ycur >= first_chk, (ycur >= first_chk) ? len : 2);
    end
  endtask

  initial forever begin
    item_t it;
    @(negedge clk);
    #0.5;
    if (q.size() > 0) begin
      it = q.pop_front();
      check_out(it.tag, it.e);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin shd[i] = 8'h0; act[i] = 8'h0; end
    repeat (4) @(negedge clk);
    check_out("R1 outputs during reset", 4'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_out("R1 outputs after reset", 4'b0);

    cur_tag = "R1 R10 overlay disabled after reset";
    vfield(0, 0, 8'h0);
    lines(30, 1, 60);

    for (int i = 0; i < 12; i++) wr(i, {3'(i % 7 + 1), 5'(i * 3 + 1)});
    wr(12, 8'h01); wr(13, 8'h01); wr(14, 8'h01); wr(15, 8'h3E);
    cur_tag = "R2 R4 R5 R6 R7 R11 scale1 plain, test bits ignored";
    vfield(0, 0, 8'h0);
    lines(30, 17, 92);
    wr(14, 8'h00);
    wr(0, 8'hFF);
    cur_tag = "R3 mid-field write deferred";
    lines(26, 17, 92);

    cur_tag = "R3 R10 write coincident with field start";
    vfield(1, 14, 8'h05);
    lines(56, 17, 92);
    cur_tag = "R3 R8 R10 solid black background";
    vfield(0, 0, 8'h0);
    lines(56, 17, 92);

    for (int i = 0; i < 12; i++) wr(i, {3'(7 - i % 7), 5'((i * 5 + 2) % 30 + 1)});
    wr(12, 8'h11); wr(13, 8'h02); wr(14, 8'hA3); wr(15, 8'h00);
    cur_tag = "R5 R6 R7 R8 scale2 halo";
    vfield(0, 0, 8'h0);
    lines(92, 17, 176);

    wr(2, 8'hE0); wr(7, 8'hDF);
    wr(12, 8'h21); wr(13, 8'h00); wr(14, 8'h45); wr(15, 8'h05);
    cur_tag = "R8 R9 R11 scale3 solid, blank and off codes, fb gated";
    vfield(0, 0, 8'h0);
    lines(128, 17, 226);

    for (int i = 0; i < 12; i++) wr(i, {3'(i % 6 + 1), 5'(i + 10)});
    wr(3, 8'hC0); wr(9, 8'h7F);
    wr(12, 8'h31); wr(13, 8'h01); wr(14, 8'h3B); wr(15, 8'h13);
    cur_tag = "R7 R9 R11 scale4 codes shown, smoothing off, green gated";
    vfield(0, 0, 8'h0);
    lines(100, 17, 312);

    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule